// File: doc/BRIEF.md
# Cache/Memory Component Register File

This block is the register file for the cache and memory part of a CXL 2.0 component. Software reaches it over a simple 32-bit register bus. A request carries a word address, a write flag, a wide-access flag and write data. A response comes back one cycle later. The block holds three groups of registers:

- a chain of capability headers, one word per entry;
- the RAS error mask and severity registers;
- the registers of one memory decoder.

A static component-type input selects the capability entries that exist. The same input selects the write masks that shape every stored word.

Every write passes through a per-word mask of writable bits, so read-only bits keep their value. The decoder control word has one special case. When a write sets its commit request bit, the stored word shows the request as done: commit is cleared, error is cleared and committed is set. The next read of that word already shows the acknowledge.

Top module: `cm_regfile`

## Requirements
- R1: Every request gets `rsp_valid` high in the cycle after `req_valid` is sampled, and only then. After reset `rsp_valid` is low.
- R2: A request with `req_wide` high is an unsupported 8-byte access. As a read it returns zero. As a write it changes no register.
- R3: A write stores `(wdata & mask) | (old & ~mask)`, using the mask of the addressed word. Words whose mask is zero ignore writes. This covers the error status words 0x10 and 0x13 and the RAS control word 0x15.
- R4: The decoder control word is at word 0x28. Commit is bit 9, committed is bit 10 and error is bit 11. A write with bit 9 set stores the masked value, then clears bits 9 and 11 and sets bit 10. Bits 10 and 11 are read-only, so a write without commit keeps bit 10. A read in the cycle after the commit write returns the result.
- R5: Primary header at word 0 = {count[31:24], 1[23:20], 1[19:16], 16'h0001}. `comp_type` codes are 0 downstream port, 1 generic device, 2 upstream port, 3 type-3 device, 4 logical device and 5 root port. Codes 6 and 7 behave like 0. The entry count is 2 for codes 0 and 1, 3 for codes 2 to 4, and 5 for code 5.
- R6: Each sub-header is {pointer[31:20], version[19:16], ID[15:0]}:
  - word 1, RAS: 0x01020002;
  - word 2, link: 0x01820004;
  - word 3, decoder: 0x02010005, present when the count is at least 3;
  - word 4, extended security: 0x01C10006, present when the count is 5;
  - word 5, snoop: 0x01E10008, present when the count is 5.
  A header that is absent reads zero.
- R7: RAS words reset as follows. Uncorrectable mask (0x11) and severity (0x12) are 0x1CFFF, with write mask 0x1CFFF. Correctable mask (0x14) is 0x7F, with write mask 0x7F. Words 0x10, 0x13 and 0x15 read zero.
- R8: The decoder capability (word 0x20) reads 0x310. This means one decoder, target count 1 in bits 7:4, 256-byte interleave in bit 8, 4 KB interleave in bit 9 and no poison support. Global control (word 0x21) resets to 0 and has write mask 0x3.
- R9: Decoder 0 words and write masks, all resetting to 0:
  - base low (0x24) and size low (0x26): 0xF0000000;
  - base high (0x25) and size high (0x27): fully writable;
  - control (0x28): 0x13FF.
- R10: Target-list low (0x29) has write mask 0xF0000000 for device codes 1, 3 and 4, and 0xFFFFFFFF for the other codes. Target-list high (0x2A) is fully writable.
- R11: Words outside the implemented set read zero and ignore writes. The decoder words read zero and ignore writes when the entry count is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| comp_type | input | 3 | Static component type code |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | Unsupported 8-byte access |
| req_addr | input | IDX_W | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_rdata | output | 32 | Read data (zero for writes and wide accesses) |

## Verification
Every result is due exactly one cycle after its request, since the response register is the only stage between the bus and the read data. A write updates storage on the same edge that registers its response. Therefore a read issued in the very next cycle, the commit acknowledge included, sees the new value. The bench drives each request at a falling edge and samples the response at the following falling edge, half a cycle after the registering edge. Back-to-back reads are checked cycle by cycle to cover the one-cycle latency with no gaps.

// File: rtl/cm_regfile_pkg.sv
package cm_regfile_pkg;

  // word indices of the register map
  localparam int W_PRIM      = 'h00;
  localparam int W_RAS_HDR   = 'h01;
  localparam int W_LINK_HDR  = 'h02;
  localparam int W_HDM_HDR   = 'h03;
  localparam int W_XSEC_HDR  = 'h04;
  localparam int W_SNOOP_HDR = 'h05;

  localparam int W_RAS_BASE  = 'h10;
  localparam int W_LINK_BASE = 'h18;
  localparam int W_XSEC_BASE = 'h1C;
  localparam int W_SNP_BASE  = 'h1E;
  localparam int W_HDM_BASE  = 'h20;

  localparam int W_DEC_CAP   = 'h20;
  localparam int W_DEC_CTRL  = 'h28;

  localparam int CTRL_COMMIT_B    = 9;
  localparam int CTRL_COMMITTED_B = 10;
  localparam int CTRL_ERR_B       = 11;

  localparam logic [31:0] DEC_CAP_VAL = 32'h0000_0310;

  localparam int RAS_SLOTS = 3;
  localparam int HDM_SLOTS = 8;
  localparam int HDM_CTRL_SLOT = 5;

  function automatic logic [7:0] cap_count(input logic [2:0] t);
    case (t)
      3'd2, 3'd3, 3'd4: cap_count = 8'd3;
      3'd5:             cap_count = 8'd5;
      default:          cap_count = 8'd2;
    endcase
  endfunction

  function automatic logic is_dev_like(input logic [2:0] t);
    is_dev_like = (t == 3'd1) || (t == 3'd3) || (t == 3'd4);
  endfunction

  function automatic logic [31:0] sub_hdr(input int ptr, input int ver, input int id);
    sub_hdr = {12'(ptr), 4'(ver), 16'(id)};
  endfunction

  function automatic logic [31:0] merge_wr(input logic [31:0] old_v,
                                           input logic [31:0] new_v,
                                           input logic [31:0] msk);
    merge_wr = (new_v & msk) | (old_v & ~msk);
  endfunction

  // RAS stored words: uncorrectable mask, severity, correctable mask
  function automatic int ras_word(input int s);
    case (s)
      0:       ras_word = W_RAS_BASE + 1;
      1:       ras_word = W_RAS_BASE + 2;
      default: ras_word = W_RAS_BASE + 4;
    endcase
  endfunction

  function automatic logic [31:0] ras_mask(input int s);
    ras_mask = (s == 2) ? 32'h0000_007F : 32'h0001_CFFF;
  endfunction

  // decoder stored words
  function automatic int hdm_word(input int s);
    case (s)
      0:       hdm_word = W_HDM_BASE + 'h1;
      1:       hdm_word = W_HDM_BASE + 'h4;
      2:       hdm_word = W_HDM_BASE + 'h5;
      3:       hdm_word = W_HDM_BASE + 'h6;
      4:       hdm_word = W_HDM_BASE + 'h7;
      5:       hdm_word = W_HDM_BASE + 'h8;
      6:       hdm_word = W_HDM_BASE + 'h9;
      default: hdm_word = W_HDM_BASE + 'hA;
    endcase
  endfunction

  function automatic logic [31:0] hdm_mask(input int s, input logic dev_like);
    case (s)
      0:       hdm_mask = 32'h0000_0003;
      1, 3:    hdm_mask = 32'hF000_0000;
      5:       hdm_mask = 32'h0000_13FF;
      6:       hdm_mask = dev_like ? 32'hF000_0000 : 32'hFFFF_FFFF;
      default: hdm_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cm_cap_chain.sv
module cm_cap_chain
  import cm_regfile_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [2:0]       comp_type,
  input  logic [IDX_W-1:0] idx,
  output logic [31:0]      rdata
);

  logic [7:0] cnt;
  assign cnt = cap_count(comp_type);

  always_comb begin
    rdata = '0;
    if (idx == IDX_W'(W_PRIM))
      rdata = {cnt, 4'd1, 4'd1, 16'h0001};
    else if (idx == IDX_W'(W_RAS_HDR))
      rdata = sub_hdr(W_RAS_BASE, 2, 2);
    else if (idx == IDX_W'(W_LINK_HDR))
      rdata = sub_hdr(W_LINK_BASE, 2, 4);
    else if (idx == IDX_W'(W_HDM_HDR) && cnt >= 8'd3)
      rdata = sub_hdr(W_HDM_BASE, 1, 5);
    else if (idx == IDX_W'(W_XSEC_HDR) && cnt >= 8'd5)
      rdata = sub_hdr(W_XSEC_BASE, 1, 6);
    else if (idx == IDX_W'(W_SNOOP_HDR) && cnt >= 8'd5)
      rdata = sub_hdr(W_SNP_BASE, 1, 8);
  end

endmodule

// File: rtl/cm_ras_bank.sv
module cm_ras_bank
  import cm_regfile_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);

  logic [31:0] slot_q [RAS_SLOTS];

  for (genvar s = 0; s < RAS_SLOTS; s++) begin : g_slot
    localparam logic [31:0] MSK = ras_mask(s);
    logic [31:0] q;
    logic        sel;
    assign sel = (idx == IDX_W'(ras_word(s)));
    always_ff @(posedge clk) begin
      if (rst)
        q <= MSK;
      else if (wr_en && sel)
        q <= merge_wr(q, wdata, MSK);
    end
    assign slot_q[s] = q;
  end

  // status and control words have no writable bits and read zero
  always_comb begin
    rdata = '0;
    for (int s = 0; s < RAS_SLOTS; s++)
      if (idx == IDX_W'(ras_word(s)))
        rdata = slot_q[s];
  end

endmodule

// File: rtl/cm_hdm_bank.sv
module cm_hdm_bank
  import cm_regfile_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             present,
  input  logic             dev_like,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);

  logic [31:0] slot_q [HDM_SLOTS];

  for (genvar s = 0; s < HDM_SLOTS; s++) begin : g_slot
    logic [31:0] q;
    logic [31:0] msk;
    logic [31:0] merged;
    logic        sel;
    assign msk    = hdm_mask(s, dev_like);
    assign merged = merge_wr(q, wdata, msk);
    assign sel    = present && (idx == IDX_W'(hdm_word(s)));
    if (s == HDM_CTRL_SLOT) begin : g_ctrl
      logic [31:0] acked;
      always_comb begin
        acked = merged;
        if (wdata[CTRL_COMMIT_B]) begin
          acked[CTRL_COMMIT_B]    = 1'b0;
          acked[CTRL_ERR_B]       = 1'b0;
          acked[CTRL_COMMITTED_B] = 1'b1;
        end
      end
      always_ff @(posedge clk) begin
        if (rst)
          q <= '0;
        else if (wr_en && sel)
          q <= acked;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)
          q <= '0;
        else if (wr_en && sel)
          q <= merged;
      end
    end
    assign slot_q[s] = q;
  end

  always_comb begin
    rdata = '0;
    if (present) begin
      if (idx == IDX_W'(W_DEC_CAP))
        rdata = DEC_CAP_VAL;
      for (int s = 0; s < HDM_SLOTS; s++)
        if (idx == IDX_W'(hdm_word(s)))
          rdata = slot_q[s];
    end
  end

endmodule

// File: rtl/cm_regfile.sv
module cm_regfile
  import cm_regfile_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       comp_type,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_wide,
  input  logic [IDX_W-1:0] req_addr,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata
);

  logic        acc_ok;
  logic        wr_en;
  logic        hdm_on;
  logic [31:0] rd_cap, rd_ras, rd_hdm, rd_all;

  assign acc_ok = req_valid && !req_wide;
  assign wr_en  = acc_ok && req_write;
  assign hdm_on = cap_count(comp_type) >= 8'd3;

  cm_cap_chain #(.IDX_W(IDX_W)) u_cap (
    .comp_type (comp_type),
    .idx       (req_addr),
    .rdata     (rd_cap)
  );

  cm_ras_bank #(.IDX_W(IDX_W)) u_ras (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .idx   (req_addr),
    .wdata (req_wdata),
    .rdata (rd_ras)
  );

  cm_hdm_bank #(.IDX_W(IDX_W)) u_hdm (
    .clk      (clk),
    .rst      (rst),
    .present  (hdm_on),
    .dev_like (is_dev_like(comp_type)),
    .wr_en    (wr_en),
    .idx      (req_addr),
    .wdata    (req_wdata),
    .rdata    (rd_hdm)
  );

  // groups occupy disjoint word ranges, each returns zero when not addressed
  assign rd_all = rd_cap | rd_ras | rd_hdm;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (acc_ok && !req_write) ? rd_all : '0;
    end
  end

endmodule

// File: rtl/cm_regfile_chk.sv
module cm_regfile_chk
  import cm_regfile_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       comp_type,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_wide,
  input logic [IDX_W-1:0] req_addr,
  input logic             commit_bit,
  input logic             rsp_valid,
  input logic [31:0]      rsp_rdata
);

  logic rd_ok;
  logic hdm_on;
  logic committed_seen;

  assign rd_ok  = req_valid && !req_write && !req_wide;
  assign hdm_on = cap_count(comp_type) >= 8'd3;

  always_ff @(posedge clk) begin
    if (rst)
      committed_seen <= 1'b0;
    else if (req_valid && req_write && !req_wide && hdm_on &&
             req_addr == IDX_W'(W_DEC_CTRL) && commit_bit)
      committed_seen <= 1'b1;
  end

  AST_RSP_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R1
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R1
  AST_WIDE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_wide && !req_write) |=> (rsp_rdata == 32'h0)); // R2
  AST_COR_MASK_RO: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && req_addr == IDX_W'(W_RAS_BASE + 4)) |=> (rsp_rdata[31:7] == '0)); // R3
  AST_COMMIT_ACK: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && hdm_on && req_addr == IDX_W'(W_DEC_CTRL)) |=>
      (!rsp_rdata[CTRL_COMMIT_B] && !rsp_rdata[CTRL_ERR_B] &&
       rsp_rdata[CTRL_COMMITTED_B] == committed_seen)); // R4
  AST_PRIM_HDR: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && req_addr == IDX_W'(W_PRIM)) |=>
      (rsp_rdata[15:0] == 16'h0001 && rsp_rdata[31:24] == cap_count(comp_type))); // R5
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && req_addr == '1) |=> (rsp_rdata == 32'h0)); // R11

endmodule

bind cm_regfile cm_regfile_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .comp_type  (comp_type),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_wide   (req_wide),
  .req_addr   (req_addr),
  .commit_bit (req_wdata[9]),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata)
);

// File: tb/cm_regfile_tb.sv
`timescale 1ns/1ps
module cm_regfile_tb;

  localparam int IDX_W = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       comp_type = 3'd3;
  logic             req_valid = 1'b0;
  logic             req_write = 1'b0;
  logic             req_wide = 1'b0;
  logic [IDX_W-1:0] req_addr = '0;
  logic [31:0]      req_wdata = '0;
  logic             rsp_valid;
  logic [31:0]      rsp_rdata;

  int n_tot = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cm_regfile #(.IDX_W(IDX_W)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .comp_type (comp_type),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_wide  (req_wide),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reset_to(input logic [2:0] t);
    @(negedge clk);
    rst = 1'b1;
    comp_type = t;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    rst = 1'b0;
  endtask

  task automatic rd(input int a, input logic wide, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_wide = wide;
    req_addr = IDX_W'(a);
    @(negedge clk);
    req_valid = 1'b0; req_wide = 1'b0;
    check("R1 rsp_valid after read", {31'b0, rsp_valid}, 32'h1);
    d = rsp_rdata;
  endtask

  task automatic wr(input int a, input logic [31:0] v, input logic wide);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_wide = wide;
    req_addr = IDX_W'(a); req_wdata = v;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0;
    check("R1 rsp_valid after write", {31'b0, rsp_valid}, 32'h1);
  endtask

  task automatic expect_rd(input string req, input int a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, 1'b0, d);
    check(req, d, exp);
  endtask

  task automatic t_reset_image();
    reset_to(3'd3);
    expect_rd("R7 unc status", 'h10, 32'h0);
    expect_rd("R7 unc mask", 'h11, 32'h0001_CFFF);
    expect_rd("R7 unc severity", 'h12, 32'h0001_CFFF);
    expect_rd("R7 cor status", 'h13, 32'h0);
    expect_rd("R7 cor mask", 'h14, 32'h0000_007F);
    expect_rd("R7 cap ctrl", 'h15, 32'h0);
    expect_rd("R8 decoder capability", 'h20, 32'h0000_0310);
    expect_rd("R8 global ctrl reset", 'h21, 32'h0);
    expect_rd("R9 ctrl reset", 'h28, 32'h0);
  endtask

  task automatic t_headers(input logic [2:0] t);
    int cnt;
    cnt = (t == 3'd5) ? 5 : ((t >= 3'd2 && t <= 3'd4) ? 3 : 2);
    reset_to(t);
    expect_rd("R5 primary header", 'h00, {8'(cnt), 24'h11_0001});
    expect_rd("R6 ras header", 'h01, 32'h0102_0002);
    expect_rd("R6 link header", 'h02, 32'h0182_0004);
    expect_rd("R6 decoder header", 'h03, (cnt >= 3) ? 32'h0201_0005 : 32'h0);
    expect_rd("R6 ext security header", 'h04, (cnt == 5) ? 32'h01C1_0006 : 32'h0);
    expect_rd("R6 snoop header", 'h05, (cnt == 5) ? 32'h01E1_0008 : 32'h0);
  endtask

  task automatic t_ras_masks();
    reset_to(3'd3);
    wr('h14, 32'hFFFF_FF00, 1'b0);
    expect_rd("R3 cor mask clear", 'h14, 32'h0);
    wr('h14, 32'hFFFF_FFFF, 1'b0);
    expect_rd("R3 cor mask set", 'h14, 32'h7F);
    wr('h11, 32'h0, 1'b0);
    expect_rd("R3 unc mask clear", 'h11, 32'h0);
    wr('h11, 32'hFFFF_FFFF, 1'b0);
    expect_rd("R3 unc mask set", 'h11, 32'h0001_CFFF);
    wr('h12, 32'h0000_3000, 1'b0);
    expect_rd("R3 severity reserved bits", 'h12, 32'h0);
    wr('h10, 32'hFFFF_FFFF, 1'b0);
    expect_rd("R3 status ignores write", 'h10, 32'h0);
  endtask

  task automatic t_hdm_masks(input logic [2:0] t);
    reset_to(t);
    wr('h21, 32'hFFFF_FFFF, 1'b0);
    expect_rd("R8 global ctrl mask", 'h21, 32'h3);
    wr('h24, 32'hFFFF_FFFF, 1'b0);
    expect_rd("R9 base low mask", 'h24, 32'hF000_0000);
    wr('h25, 32'h1234_5678, 1'b0);
    expect_rd("R9 base high", 'h25, 32'h1234_5678);
    wr('h26, 32'h5FFF_FFFF, 1'b0);
    expect_rd("R9 size low mask", 'h26, 32'h5000_0000);
    wr('h27, 32'hDEAD_BEEF, 1'b0);
    expect_rd("R9 size high", 'h27, 32'hDEAD_BEEF);
    wr('h28, 32'h0000_1DFF, 1'b0);
    expect_rd("R9 ctrl mask", 'h28, 32'h0000_11FF);
    wr('h29, 32'hFFFF_FFFF, 1'b0);
    expect_rd("R10 target list low", 'h29,
              (t == 3'd3 || t == 3'd4) ? 32'hF000_0000 : 32'hFFFF_FFFF);
    wr('h2A, 32'h8765_4321, 1'b0);
    expect_rd("R10 target list high", 'h2A, 32'h8765_4321);
  endtask

  task automatic t_commit();
    reset_to(3'd5);
    wr('h28, 32'hFFFF_0AA5, 1'b0);
    expect_rd("R4 commit ack", 'h28, 32'h0000_04A5);
    wr('h28, 32'h0000_000F, 1'b0);
    expect_rd("R4 committed kept", 'h28, 32'h0000_040F);
  endtask

  task automatic t_wide();
    logic [31:0] d;
    reset_to(3'd3);
    wr('h25, 32'hA5A5_A5A5, 1'b0);
    wr('h25, 32'h1234_5678, 1'b1);
    expect_rd("R2 wide write dropped", 'h25, 32'hA5A5_A5A5);
    wr('h28, 32'h0000_0200, 1'b1);
    expect_rd("R2 wide commit dropped", 'h28, 32'h0);
    rd('h14, 1'b1, d);
    check("R2 wide read zero", d, 32'h0);
  endtask

  task automatic t_unmapped();
    reset_to(3'd3);
    wr('h3F, 32'hFFFF_FFFF, 1'b0);
    expect_rd("R11 unmapped read", 'h3F, 32'h0);
    wr('h00, 32'h0, 1'b0);
    expect_rd("R11 header not writable", 'h00, 32'h0311_0001);
    reset_to(3'd0);
    wr('h25, 32'hFFFF_FFFF, 1'b0);
    expect_rd("R11 decoder absent write", 'h25, 32'h0);
    expect_rd("R11 decoder absent cap", 'h20, 32'h0);
  endtask

  task automatic t_back2back();
    reset_to(3'd3);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = IDX_W'('h00);
    @(negedge clk);
    check("R1 b2b first valid", {31'b0, rsp_valid}, 32'h1);
    check("R1 b2b first data", rsp_rdata, 32'h0311_0001);
    req_addr = IDX_W'('h14);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 b2b second data", rsp_rdata, 32'h7F);
    @(negedge clk);
    check("R1 idle no response", {31'b0, rsp_valid}, 32'h0);
  endtask

  initial begin
    #1_000_000;
    n_tot++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    t_reset_image();
    for (int t = 0; t < 6; t++) t_headers(3'(t));
    t_ras_masks();
    t_hdm_masks(3'd3);
    t_hdm_masks(3'd5);
    t_commit();
    t_wide();
    t_unmapped();
    t_back2back();
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

endmodule